// File: doc/BRIEF.md
# Outbound Address Window Translator

This block sits between a local bus and an external expansion bus. It claims a local request for one of three outbound windows and rewrites the address for the far side. Each window is described by one 32-bit word. That word holds a local base byte, a size mask byte and a target byte, so every window is sized and aligned in 16 MB steps. A single shared control word carries one byte per window. Each byte turns the window on or off, marks it as I/O or memory space, and picks the flavour of read command to issue.

For each valid request the block compares the top address byte against every enabled window. The lowest-numbered window that matches wins. The block then replaces the masked-out bits of the top byte with the target byte and passes the lower 24 bits through unchanged. It reports the window index, the space flag and the read command. When nothing matches, it raises a miss flag and drives a zero address. The decode is combinational and the result is registered once. The bus signalling and data movement are handled elsewhere.

Top module: `outwin_xlate`

## Requirements
- R1: After reset, every output is zero, both register sets are zero, and every request misses until a window is enabled.
- R2: Register select 0, 1 and 2 writes the word of window 0, 1 and 2. In that word, bits 31:24 are the local base byte, bits 23:16 the mask byte (size in 16 MB units minus one), and bits 15:8 the target byte.
- R3: Register select 3 writes the control word. Window 0 owns bits 31:24, window 1 bits 23:16 and window 2 bits 15:8. Bit 0 of a byte enables its window, and a disabled window never claims an address.
- R4: An enabled window claims a request when the top address byte and the base byte agree on every bit where the mask byte is 0.
- R5: On a hit, the top output byte takes the target byte where the mask is 0 and the request byte where the mask is 1. Bits 23:0 are copied unchanged, and target or base bits under the mask have no effect.
- R6: Bit 3 of the winning control byte drives out_io: 1 for an I/O window, 0 for a memory window.
- R7: Bits 2:1 of the winning control byte select out_rd_cmd: 00 plain read, 01 read-line, 10 read-multiple. The unused code 11 is issued as 00.
- R8: When several enabled windows claim a request, the lowest-numbered one wins, and out_win gives its index.
- R9: A valid request that no window claims gives out_miss=1, out_addr=0, out_io=0, out_rd_cmd=00 and out_win=0.
- R10: The result of a request sampled at a clock edge appears on the outputs right after that edge, so requests on consecutive cycles give consecutive results. A cycle without a request gives out_valid=0 with all other outputs zero.
- R11: A register write at a clock edge governs a request sampled at the very next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0..2 window words, 3 control word |
| cfg_wdata | input | 32 | Register write data |
| req_valid | input | 1 | Local request present |
| req_addr | input | 32 | Local request address |
| out_valid | output | 1 | Result present, one cycle after the request |
| out_miss | output | 1 | No window claimed the request |
| out_addr | output | 32 | Translated address, zero on a miss |
| out_io | output | 1 | 1 for I/O space, 0 for memory space |
| out_rd_cmd | output | 2 | Read command: 00 plain, 01 line, 10 multiple |
| out_win | output | 2 | Index of the claiming window |

## Verification
Every request is due on the outputs one edge after it is sampled. A register write becomes effective for the request sampled on the following edge. The driver stamps each expected item with the cycle count at which it was driven. The monitor, sampling a moment after each falling edge, pops only items stamped with an earlier cycle, so each comparison lands exactly on the cycle after the stimulus. Idle and configuration cycles also push an all-zero expectation, so every cycle is compared, including those that follow a write.

// File: rtl/owx_pkg.sv
package owx_pkg;

    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        RD_PLAIN = 2'b00,
        RD_LINE  = 2'b01,
        RD_MULTI = 2'b10,
        RD_RSVD  = 2'b11
    } rd_kind_e;

    typedef struct packed {
        logic [FIELD_W-1:0] base;
        logic [FIELD_W-1:0] mask;
        logic [FIELD_W-1:0] target;
    } win_fields_t;

    typedef struct packed {
        logic [3:0] spare;
        logic       is_io;
        rd_kind_e   kind;
        logic       enable;
    } win_ctrl_t;

    typedef struct packed {
        logic     hit;
        logic     is_io;
        rd_kind_e cmd;
    } win_verdict_t;

    function automatic win_fields_t unpack_window(input logic [31:0] word);
        win_fields_t f;
        f.base   = word[31:24];
        f.mask   = word[23:16];
        f.target = word[15:8];
        return f;
    endfunction

    function automatic logic page_match(input logic [FIELD_W-1:0] page,
                                        input win_fields_t f);
        return ((page ^ f.base) & ~f.mask) == '0;
    endfunction

    function automatic logic [FIELD_W-1:0] page_remap(input logic [FIELD_W-1:0] page,
                                                      input win_fields_t f);
        return (f.target & ~f.mask) | (page & f.mask);
    endfunction

    function automatic rd_kind_e legal_cmd(input rd_kind_e k);
        return (k == RD_RSVD) ? RD_PLAIN : k;
    endfunction

endpackage

// File: rtl/owx_regs.sv
module owx_regs
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = $clog2(NUM_WIN + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] win_word [NUM_WIN],
    output logic [DATA_W-1:0] ctrl_word
);
    localparam logic [SEL_W-1:0] CTRL_SEL = SEL_W'(NUM_WIN);

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(i);
        always_ff @(posedge clk) begin
            if (rst)
                win_word[i] <= '0;
            else if (wr && sel == MY_SEL)
                win_word[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_word <= '0;
        else if (wr && sel == CTRL_SEL)
            ctrl_word <= wdata;
    end

endmodule

// File: rtl/owx_window_match.sv
module owx_window_match
    import owx_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [31:0]        win_word,
    input  logic [7:0]         ctrl_byte,
    input  logic [ADDR_W-1:0]  addr,
    output win_verdict_t       verdict,
    output logic [ADDR_W-1:0]  mapped
);
    localparam int PAGE_LSB = ADDR_W - FIELD_W;

    win_fields_t        fields;
    win_ctrl_t          ctrl;
    logic [FIELD_W-1:0] page;

    always_comb begin
        fields = unpack_window(win_word);
        ctrl   = win_ctrl_t'(ctrl_byte);
        page   = addr[ADDR_W-1:PAGE_LSB];

        verdict.hit   = ctrl.enable && page_match(page, fields);
        verdict.is_io = ctrl.is_io;
        verdict.cmd   = legal_cmd(ctrl.kind);

        mapped = {page_remap(page, fields), addr[PAGE_LSB-1:0]};
    end

endmodule

// File: rtl/owx_priority_pick.sv
module owx_priority_pick
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  win_verdict_t       verdict [NUM_WIN],
    input  logic [ADDR_W-1:0]  mapped  [NUM_WIN],
    output logic [NUM_WIN-1:0] grant,
    output logic               any_hit,
    output logic [ADDR_W-1:0]  sel_addr,
    output logic               sel_io,
    output rd_kind_e           sel_cmd,
    output logic [IDX_W-1:0]   sel_idx
);
    always_comb begin
        grant    = '0;
        any_hit  = 1'b0;
        sel_addr = '0;
        sel_io   = 1'b0;
        sel_cmd  = RD_PLAIN;
        sel_idx  = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (verdict[i].hit && !any_hit) begin
                any_hit  = 1'b1;
                grant[i] = 1'b1;
                sel_addr = mapped[i];
                sel_io   = verdict[i].is_io;
                sel_cmd  = verdict[i].cmd;
                sel_idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/owx_out_stage.sv
module owx_out_stage
    import owx_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              any_hit,
    input  logic [ADDR_W-1:0] sel_addr,
    input  logic              sel_io,
    input  rd_kind_e          sel_cmd,
    input  logic [IDX_W-1:0]  sel_idx,
    output logic              out_valid,
    output logic              out_miss,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_io,
    output logic [1:0]        out_rd_cmd,
    output logic [IDX_W-1:0]  out_win
);
    logic take;

    always_comb take = req_valid && any_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_miss   <= 1'b0;
            out_addr   <= '0;
            out_io     <= 1'b0;
            out_rd_cmd <= RD_PLAIN;
            out_win    <= '0;
        end else begin
            out_valid  <= req_valid;
            out_miss   <= req_valid && !any_hit;
            out_addr   <= take ? sel_addr : '0;
            out_io     <= take && sel_io;
            out_rd_cmd <= take ? sel_cmd : RD_PLAIN;
            out_win    <= take ? sel_idx : '0;
        end
    end

endmodule

// File: rtl/outwin_xlate.sv
module outwin_xlate
    import owx_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = $clog2(NUM_WIN + 1),
    parameter int IDX_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [SEL_W-1:0]  cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              out_valid,
    output logic              out_miss,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_io,
    output logic [1:0]        out_rd_cmd,
    output logic [IDX_W-1:0]  out_win
);
    logic [DATA_W-1:0]  win_word [NUM_WIN];
    logic [DATA_W-1:0]  ctrl_word;
    win_verdict_t       verdict  [NUM_WIN];
    logic [ADDR_W-1:0]  mapped   [NUM_WIN];
    logic [NUM_WIN-1:0] grant_vec;
    logic               any_hit;
    logic [ADDR_W-1:0]  sel_addr;
    logic               sel_io;
    rd_kind_e           sel_cmd;
    logic [IDX_W-1:0]   sel_idx;

    owx_regs #(.NUM_WIN(NUM_WIN), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (cfg_wr),
        .sel       (cfg_sel),
        .wdata     (cfg_wdata),
        .win_word  (win_word),
        .ctrl_word (ctrl_word)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
        localparam int CTRL_HI = DATA_W - 1 - FIELD_W * i;
        owx_window_match #(.ADDR_W(ADDR_W)) u_match (
            .win_word  (win_word[i][31:0]),
            .ctrl_byte (ctrl_word[CTRL_HI -: FIELD_W]),
            .addr      (req_addr),
            .verdict   (verdict[i]),
            .mapped    (mapped[i])
        );
    end

    owx_priority_pick #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_pick (
        .verdict  (verdict),
        .mapped   (mapped),
        .grant    (grant_vec),
        .any_hit  (any_hit),
        .sel_addr (sel_addr),
        .sel_io   (sel_io),
        .sel_cmd  (sel_cmd),
        .sel_idx  (sel_idx)
    );

    owx_out_stage #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .any_hit    (any_hit),
        .sel_addr   (sel_addr),
        .sel_io     (sel_io),
        .sel_cmd    (sel_cmd),
        .sel_idx    (sel_idx),
        .out_valid  (out_valid),
        .out_miss   (out_miss),
        .out_addr   (out_addr),
        .out_io     (out_io),
        .out_rd_cmd (out_rd_cmd),
        .out_win    (out_win)
    );

endmodule

// File: rtl/owx_checker.sv
module owx_checker #(
    parameter int NUM_WIN = 3,
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               req_valid,
    input logic [ADDR_W-1:0]  req_addr,
    input logic               out_valid,
    input logic               out_miss,
    input logic [ADDR_W-1:0]  out_addr,
    input logic               out_io,
    input logic [1:0]         out_rd_cmd,
    input logic [IDX_W-1:0]   out_win,
    input logic [NUM_WIN-1:0] grant
);
    localparam int PAGE_LSB = ADDR_W - 8;

    // R10
    req_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> out_valid);

    // R10
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !out_valid);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_miss && out_addr == '0 && !out_io && out_rd_cmd == 2'b00 && out_win == '0));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_miss) |-> (out_addr == '0 && !out_io && out_rd_cmd == 2'b00 && out_win == '0));

    // R5
    low_pass_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (out_miss || out_addr[PAGE_LSB-1:0] == $past(req_addr[PAGE_LSB-1:0])));

    // R7
    cmd_legal_chk: assert property (@(posedge clk) disable iff (rst)
        out_rd_cmd != 2'b11);

    // R8
    grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

endmodule

bind outwin_xlate owx_checker #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .out_valid  (out_valid),
    .out_miss   (out_miss),
    .out_addr   (out_addr),
    .out_io     (out_io),
    .out_rd_cmd (out_rd_cmd),
    .out_win    (out_win),
    .grant      (grant_vec)
);

// File: tb/outwin_xlate_bench.sv
module outwin_xlate_bench;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        int          cyc;
        string       tag;
        logic        v;
        logic        m;
        logic [31:0] a;
        logic        io;
        logic [1:0]  c;
        logic [1:0]  w;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid, out_miss, out_io;
    logic [31:0] out_addr;
    logic [1:0]  out_rd_cmd, out_win;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    logic [31:0] m_win [3];
    logic [31:0] m_ctrl;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    outwin_xlate u_outwin_xlate (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_addr(req_addr),
        .out_valid(out_valid), .out_miss(out_miss), .out_addr(out_addr),
        .out_io(out_io), .out_rd_cmd(out_rd_cmd), .out_win(out_win)
    );

    function automatic exp_t predict(input logic v, input logic [31:0] a, input string tag);
        exp_t e;
        e.cyc = cyc; e.tag = tag; e.v = v;
        e.m = v; e.a = '0; e.io = 0; e.c = 2'b00; e.w = 2'd0;
        if (v) begin
            for (int i = 2; i >= 0; i--) begin
                logic [7:0] cb, b, mk, t;
                cb = m_ctrl[31-8*i -: 8];
                b = m_win[i][31:24]; mk = m_win[i][23:16]; t = m_win[i][15:8];
                if (cb[0] && (((a[31:24] ^ b) & ~mk) == 8'h00)) begin
                    e.m  = 0;
                    e.a  = {(t & ~mk) | (a[31:24] & mk), a[23:0]};
                    e.io = cb[3];
                    e.c  = (cb[2:1] == 2'b11) ? 2'b00 : cb[2:1];
                    e.w  = 2'(i);
                end
            end
        end
        return e;
    endfunction

    task automatic req(input logic v, input logic [31:0] a, input string tag);
        @(negedge clk);
        cfg_wr = 0; req_valid = v; req_addr = a;
        q.push_back(predict(v, a, tag));
    endtask

    task automatic wr_reg(input logic [1:0] s, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = s; cfg_wdata = d; req_valid = 0; req_addr = '0;
        q.push_back(predict(0, '0, "cfg"));
        if (s == 2'd3) m_ctrl = d; else m_win[s] = d;
    endtask

    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].cyc < cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (out_valid !== e.v || out_miss !== e.m || out_addr !== e.a ||
                out_io !== e.io || out_rd_cmd !== e.c || out_win !== e.w) begin
                errors++;
                $display("FAIL %s: got v=%b m=%b a=%h io=%b c=%b w=%0d exp v=%b m=%b a=%h io=%b c=%b w=%0d",
                         e.tag, out_valid, out_miss, out_addr, out_io, out_rd_cmd, out_win,
                         e.v, e.m, e.a, e.io, e.c, e.w);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 5000);
        errors++; checks++;
        $display("FAIL watchdog: got hung run exp completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        m_win[0] = '0; m_win[1] = '0; m_win[2] = '0; m_ctrl = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        checks++;
        if (out_valid !== 0 || out_miss !== 0 || out_addr !== 0 || out_io !== 0 ||
            out_rd_cmd !== 0 || out_win !== 0) begin
            errors++;
            $display("FAIL R1 reset outputs: got v=%b m=%b a=%h exp all zero", out_valid, out_miss, out_addr);
        end
        req(1, 32'h1234_5678, "R1 miss after reset");
        // window 0: base 10, mask 00, target 80
        wr_reg(2'd0, 32'h1000_8000);
        req(1, 32'h10AB_CDEF, "R3 disabled window no claim");
        // window 0 enabled, read-line, memory
        wr_reg(2'd3, 32'h0300_0000);
        req(1, 32'h10AB_CDEF, "R11 R2 R5 write seen next cycle");
        req(1, 32'h1100_0000, "R4 R9 outside window misses");
        req(0, 32'h10AB_CDEF, "R10 idle cycle zero");
        // window 1: base 20, mask 0F (256MB), target 40, I/O, read-multiple
        wr_reg(2'd1, 32'h200F_4000);
        wr_reg(2'd3, 32'h030D_0000);
        req(1, 32'h2A00_0010, "R4 R5 R6 R7 masked window");
        req(1, 32'h2FFF_FFFF, "R5 top of window");
        req(1, 32'h3000_0000, "R4 R9 just above window");
        // window 2 covers everything, reserved read code 11
        wr_reg(2'd2, 32'h00FF_0000);
        wr_reg(2'd3, 32'h030D_0700);
        req(1, 32'h1000_0004, "R8 window0 beats window2");
        req(1, 32'h2B00_0000, "R8 window1 beats window2");
        req(1, 32'h5500_0000, "R7 reserved code issued plain");
        wr_reg(2'd3, 32'h000D_0700);
        req(1, 32'h1000_0004, "R3 R8 disabled window0 falls to window2");
        // target and base bits under the mask are ignored
        wr_reg(2'd1, 32'h2C0F_4F00);
        req(1, 32'h2A12_3456, "R5 masked target and base bits ignored");
        req(1, 32'h2000_0001, "R4 R10 back to back 1");
        req(1, 32'h9900_0002, "R10 back to back 2");
        req(0, 32'h0, "R10 idle after burst");
        // memory window with plain read
        wr_reg(2'd3, 32'h0100_0000);
        req(1, 32'h10FF_FFFF, "R6 R7 memory plain read");
        req(1, 32'hFF00_0000, "R3 R9 others disabled");
        req(0, 32'h0, "R10 final idle");
        repeat (3) @(negedge clk);
        #2;
        if (q.size() != 0) begin
            errors++; checks++;
            $display("FAIL R10 drain: got %0d pending exp 0", q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule